// File: doc/BRIEF.md
# Sprite Scanline Renderer

This block paints the sprite layer of one display line into a line buffer once the background pass has filled that line. A pulse on `start` latches a line number and a record-bank select. The block then walks the sprite record table, testing one 32-bit record per cycle against the line. Records that cover the line are queued, together with their index, in a small visible-sprite queue. A separate draw engine pops queued sprites and spends one setup cycle plus sixteen pixel cycles on each. For every pixel it fetches a whole image byte, cuts out a 2-, 4- or 8-bit colour index, looks that index up in the sprite palette, and writes the colour into the line buffer unless the palette entry is marked transparent.

Because the queue decouples the scan from the draw, the record scan of later sprites runs while earlier sprites are still being painted. When the queue is full the scan waits instead of dropping records. Low colour depths let two (4-bit) or four (2-bit) sprites share the same image bytes, each picking its own field. All three memories and the line buffer are external synchronous ports with one cycle of read latency.

Top module: `sprite_line_renderer`

## Requirements
- R1: After an accepted start the block reads records at `recAddr = {bank, index}` with index 0, 1, ..., 255 in ascending order, exactly once each, at most one read per cycle. Record fields: x in bits [8:0], y in bits [24:16].
- R2: A record is visible when `(line - y) mod 512 < 16`. A record that is not visible produces no line-buffer write.
- R3: Each visible sprite takes exactly 17 draw cycles (one setup cycle plus 16 pixel cycles, with at most 16 image reads in a row). A line with V visible sprites finishes no sooner than 17·V and no sooner than 256 cycles after start, and no later than 256 + 17·V + 12 cycles. When all sprites are visible it finishes within 17·V + 12 cycles.
- R4: The visible-sprite queue holds 16 entries. When it is full the scan stalls and skips no record, so a line where all 256 sprites are visible draws all 256.
- R5: Pixel column c (0..15) of a visible sprite reads image address `{rec[31:25], row, c}` where row = `(line - y) mod 16`.
- R6: Depth field rec[12:11]: 01 selects 4-bit mode, in which rec[9] picks the nibble (0 = bits [3:0], 1 = bits [7:4]). 10 selects 2-bit mode, in which rec[10:9] = k picks bits [2k+1:2k]. 00 and 11 use the whole byte.
- R7: The palette index is the whole byte in 8-bit mode, `{0, rec[15:13], nibble}` in 4-bit mode and `{000, rec[15:13], field}` in 2-bit mode. A palette entry with bit 15 set writes nothing. Any other entry produces exactly one write.
- R8: The write goes to address `(x + c) mod 512` with data equal to palette bits [14:0]. Sprites are drawn in ascending index order, so where they overlap the higher index is left in the buffer.
- R9: `done` is low after reset, drops when a start is accepted, and rises once the scan, the queue and the pixel pipeline are all empty. It then stays high until the next start. A start while a line is in progress is ignored.
- R10: After reset no memory read and no line-buffer write is issued until a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a line (ignored while busy) |
| lineNum | input | 9 | Line to render, sampled at start |
| bankSel | input | 1 | Record bank, sampled at start |
| recRe | output | 1 | Record read enable |
| recAddr | output | 9 | Record address {bank, index} |
| recData | input | 32 | Record word, one cycle after recRe |
| imgRe | output | 1 | Image read enable |
| imgAddr | output | 15 | Image byte address {image, row, column} |
| imgData | input | 8 | Image byte, one cycle after imgRe |
| palRe | output | 1 | Palette read enable |
| palAddr | output | 8 | Palette index |
| palData | input | 16 | Palette entry, bit 15 = transparent |
| lbWe | output | 1 | Line-buffer write enable |
| lbAddr | output | 9 | Line-buffer x coordinate |
| lbData | output | 15 | Pixel colour |
| done | output | 1 | Line finished |

## Verification
The bench sweeps many lines over random record, image and palette content and recomputes the whole 512-pixel line arithmetically. A wrong field cut, row or wrapped x therefore shows up as wrong pixels, and a reversed draw order shows up as the lower-index sprite winning an overlap. A line with every sprite visible, including rows that wrap around line 0, fills the queue for thousands of cycles. A filter that drops records when the queue is full loses sprites, and one that lets the queue overflow repeats or corrupts sprites; both are caught, and a draw loop of 16 or 18 cycles per sprite falls outside the timing window. Further tests cover a line with no visible sprite, which must produce zero writes, and a second start during a busy line, which must not change the line's result.

// File: rtl/slr_pkg.sv
package slr_pkg;

  localparam int COORD_W   = 9;
  localparam int ROW_W     = 4;
  localparam int IMG_W     = 7;
  localparam int PAL_IDX_W = 8;
  localparam int PIX_W     = 15;
  localparam int SPR_SPAN  = 16;

  typedef struct packed {
    logic [COORD_W-1:0] x;
    logic [ROW_W-1:0]   row;
    logic [IMG_W-1:0]   img;
    logic [1:0]         depth;
    logic [1:0]         field;
    logic [2:0]         palHi;
  } spr_entry_t;

  typedef struct packed {
    logic             captureLine;
    logic             issueRec;
    logic             loadSprite;
    logic             drawPix;
    logic [ROW_W-1:0] col;
  } slr_ctrl_t;

  function automatic logic [COORD_W-1:0] lineOffset(input logic [31:0] rec,
                                                    input logic [COORD_W-1:0] line);
    return line - rec[24:16];
  endfunction

  function automatic logic isVisible(input logic [31:0] rec,
                                     input logic [COORD_W-1:0] line);
    logic [COORD_W-1:0] d;
    d = lineOffset(rec, line);
    return d < COORD_W'(SPR_SPAN);
  endfunction

  function automatic spr_entry_t decodeRecord(input logic [31:0] rec,
                                              input logic [COORD_W-1:0] line);
    spr_entry_t e;
    logic [COORD_W-1:0] d;
    d       = lineOffset(rec, line);
    e.x     = rec[8:0];
    e.row   = d[ROW_W-1:0];
    e.img   = rec[31:25];
    e.depth = rec[12:11];
    e.field = rec[10:9];
    e.palHi = rec[15:13];
    return e;
  endfunction

  function automatic logic [PAL_IDX_W-1:0] paletteIndex(input logic [7:0] b,
                                                        input logic [1:0] depth,
                                                        input logic [1:0] field,
                                                        input logic [2:0] palHi);
    logic [1:0] pair;
    case (field)
      2'd0:    pair = b[1:0];
      2'd1:    pair = b[3:2];
      2'd2:    pair = b[5:4];
      default: pair = b[7:6];
    endcase
    case (depth)
      2'b01:   return {1'b0, palHi, (field[0] ? b[7:4] : b[3:0])};
      2'b10:   return {3'b000, palHi, pair};
      default: return b;
    endcase
  endfunction

endpackage

// File: rtl/slr_control.sv
module slr_control
  import slr_pkg::*;
#(
  parameter int NUM_SPR    = 256,
  parameter int FIFO_DEPTH = 16,
  localparam int IDX_W     = $clog2(NUM_SPR),
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] fifoCount,
  input  logic             fifoEmpty,
  input  logic             pipeIdle,
  output slr_ctrl_t        ctl,
  output logic [IDX_W-1:0] scanIdx,
  output logic             done
);

  logic             busy;
  logic             pendRd;
  logic             drawing;
  logic [ROW_W-1:0] col;
  logic [IDX_W:0]   scanCnt;

  logic startAccept, scanEnd, room, issue, load, finish;

  always_comb begin
    startAccept = start && !busy;
    scanEnd     = (scanCnt == (IDX_W+1)'(NUM_SPR));
    room        = (({1'b0, fifoCount} + {{CNT_W{1'b0}}, pendRd}) < (CNT_W+1)'(FIFO_DEPTH));
    issue       = busy && !scanEnd && room;
    load        = !drawing && !fifoEmpty;
    finish      = busy && scanEnd && !pendRd && fifoEmpty && !drawing && pipeIdle;

    ctl.captureLine = startAccept;
    ctl.issueRec    = issue;
    ctl.loadSprite  = load;
    ctl.drawPix     = drawing;
    ctl.col         = col;
    scanIdx         = scanCnt[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      scanCnt <= '0;
      pendRd  <= 1'b0;
      drawing <= 1'b0;
      col     <= '0;
    end else begin
      pendRd <= issue;
      if (startAccept) begin
        busy    <= 1'b1;
        done    <= 1'b0;
        scanCnt <= '0;
      end else begin
        if (issue)  scanCnt <= scanCnt + 1'b1;
        if (finish) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
      if (load) begin
        drawing <= 1'b1;
        col     <= '0;
      end else if (drawing) begin
        if (col == ROW_W'(SPR_SPAN - 1)) drawing <= 1'b0;
        col <= col + 1'b1;
      end
    end
  end

endmodule

// File: rtl/slr_datapath.sv
module slr_datapath
  import slr_pkg::*;
#(
  parameter int NUM_SPR    = 256,
  parameter int FIFO_DEPTH = 16,
  localparam int IDX_W     = $clog2(NUM_SPR),
  localparam int PTR_W     = $clog2(FIFO_DEPTH),
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1),
  localparam int IADDR_W   = IMG_W + 2 * ROW_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  slr_ctrl_t            ctl,
  input  logic [IDX_W-1:0]     scanIdx,
  input  logic [COORD_W-1:0]   lineNum,
  input  logic                 bankSel,
  output logic                 recRe,
  output logic [IDX_W:0]       recAddr,
  input  logic [31:0]          recData,
  output logic                 imgRe,
  output logic [IADDR_W-1:0]   imgAddr,
  input  logic [7:0]           imgData,
  output logic                 palRe,
  output logic [PAL_IDX_W-1:0] palAddr,
  input  logic [15:0]          palData,
  output logic                 lbWe,
  output logic [COORD_W-1:0]   lbAddr,
  output logic [PIX_W-1:0]     lbData,
  output logic [CNT_W-1:0]     fifoCount,
  output logic                 fifoEmpty,
  output logic                 pipeIdle,
  output logic [IDX_W-1:0]     curIdx
);

  logic [COORD_W-1:0] lineReg;
  logic               bankReg;
  logic               recValid;
  logic [IDX_W-1:0]   recIdx;

  spr_entry_t         qEntry [FIFO_DEPTH];
  logic [IDX_W-1:0]   qIdx   [FIFO_DEPTH];
  logic [PTR_W-1:0]   wrPtr, rdPtr;
  logic               push, pop;

  spr_entry_t         cur;

  logic               bValid;
  logic [COORD_W-1:0] bX;
  logic [1:0]         bDepth, bField;
  logic [2:0]         bPalHi;
  logic               cValid;
  logic [COORD_W-1:0] cX;

  always_comb begin
    recRe     = ctl.issueRec;
    recAddr   = {bankReg, scanIdx};
    push      = recValid && isVisible(recData, lineReg);
    pop       = ctl.loadSprite;
    fifoEmpty = (fifoCount == '0);
    imgRe     = ctl.drawPix;
    imgAddr   = {cur.img, cur.row, ctl.col};
    palRe     = bValid;
    palAddr   = paletteIndex(imgData, bDepth, bField, bPalHi);
    pipeIdle  = !bValid && !cValid && !lbWe;
  end

  always_ff @(posedge clk) begin
    if (push) begin
      qEntry[wrPtr] <= decodeRecord(recData, lineReg);
      qIdx[wrPtr]   <= recIdx;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineReg   <= '0;
      bankReg   <= 1'b0;
      recValid  <= 1'b0;
      recIdx    <= '0;
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
      cur       <= '0;
      curIdx    <= '0;
      bValid    <= 1'b0;
      bX        <= '0;
      bDepth    <= '0;
      bField    <= '0;
      bPalHi    <= '0;
      cValid    <= 1'b0;
      cX        <= '0;
      lbWe      <= 1'b0;
      lbAddr    <= '0;
      lbData    <= '0;
    end else begin
      if (ctl.captureLine) begin
        lineReg <= lineNum;
        bankReg <= bankSel;
        curIdx  <= '0;
      end
      recValid <= ctl.issueRec;
      recIdx   <= scanIdx;

      if (push) wrPtr <= (wrPtr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      fifoCount <= fifoCount + CNT_W'(push) - CNT_W'(pop);

      if (pop) begin
        cur    <= qEntry[rdPtr];
        curIdx <= qIdx[rdPtr];
      end

      bValid <= ctl.drawPix;
      bX     <= cur.x + COORD_W'(ctl.col);
      bDepth <= cur.depth;
      bField <= cur.field;
      bPalHi <= cur.palHi;

      cValid <= bValid;
      cX     <= bX;

      lbWe   <= cValid && !palData[15];
      lbAddr <= cX;
      lbData <= palData[PIX_W-1:0];
    end
  end

endmodule

// File: rtl/sprite_line_renderer.sv
module sprite_line_renderer
  import slr_pkg::*;
#(
  parameter int NUM_SPR    = 256,
  parameter int FIFO_DEPTH = 16,
  localparam int IDX_W     = $clog2(NUM_SPR),
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1),
  localparam int IADDR_W   = IMG_W + 2 * ROW_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [COORD_W-1:0]   lineNum,
  input  logic                 bankSel,
  output logic                 recRe,
  output logic [IDX_W:0]       recAddr,
  input  logic [31:0]          recData,
  output logic                 imgRe,
  output logic [IADDR_W-1:0]   imgAddr,
  input  logic [7:0]           imgData,
  output logic                 palRe,
  output logic [PAL_IDX_W-1:0] palAddr,
  input  logic [15:0]          palData,
  output logic                 lbWe,
  output logic [COORD_W-1:0]   lbAddr,
  output logic [PIX_W-1:0]     lbData,
  output logic                 done
);

  slr_ctrl_t        ctl;
  logic [IDX_W-1:0] scanIdx;
  logic [CNT_W-1:0] fifoCount;
  logic             fifoEmpty;
  logic             pipeIdle;
  logic [IDX_W-1:0] curIdx;

  slr_control #(.NUM_SPR(NUM_SPR), .FIFO_DEPTH(FIFO_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .fifoCount(fifoCount), .fifoEmpty(fifoEmpty), .pipeIdle(pipeIdle),
    .ctl(ctl), .scanIdx(scanIdx), .done(done)
  );

  slr_datapath #(.NUM_SPR(NUM_SPR), .FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .scanIdx(scanIdx),
    .lineNum(lineNum), .bankSel(bankSel),
    .recRe(recRe), .recAddr(recAddr), .recData(recData),
    .imgRe(imgRe), .imgAddr(imgAddr), .imgData(imgData),
    .palRe(palRe), .palAddr(palAddr), .palData(palData),
    .lbWe(lbWe), .lbAddr(lbAddr), .lbData(lbData),
    .fifoCount(fifoCount), .fifoEmpty(fifoEmpty), .pipeIdle(pipeIdle),
    .curIdx(curIdx)
  );

endmodule

// File: rtl/slr_checker.sv
module slr_checker #(
  parameter int NUM_SPR    = 256,
  parameter int FIFO_DEPTH = 16,
  localparam int IDX_W     = $clog2(NUM_SPR),
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             done,
  input logic             start,
  input logic             recRe,
  input logic [IDX_W:0]   recAddr,
  input logic             imgRe,
  input logic             lbWe,
  input logic [CNT_W-1:0] fifoCount,
  input logic [IDX_W-1:0] curIdx
);

  logic [7:0] imgRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) imgRun <= '0;
    else       imgRun <= imgRe ? ((imgRun == 8'hFF) ? imgRun : imgRun + 1'b1) : 8'd0;
  end

  // R1
  scan_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    recRe && $past(recRe) |-> recAddr[IDX_W-1:0] == IDX_W'($past(recAddr[IDX_W-1:0]) + 1'b1));

  // R3
  pixel_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    imgRe |-> imgRun < 8'd16);

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CNT_W'(FIFO_DEPTH));

  // R8
  draw_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    curIdx != $past(curIdx) |-> (curIdx > $past(curIdx) || curIdx == '0));

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    done && !start |=> done);

  // R9
  quiet_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !lbWe && !recRe && !imgRe);

endmodule

bind sprite_line_renderer slr_checker #(.NUM_SPR(NUM_SPR), .FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .done(done), .start(start), .recRe(recRe),
  .recAddr(recAddr), .imgRe(imgRe), .lbWe(lbWe), .fifoCount(fifoCount),
  .curIdx(curIdx)
);

// File: tb/sprite_line_renderer_tb.sv
module sprite_line_renderer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LOG_N      = 8192;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [8:0]  lineNum = '0;
  logic        bankSel = 1'b0;
  logic        recRe, imgRe, palRe, lbWe, done;
  logic [8:0]  recAddr, lbAddr;
  logic [31:0] recData = '0;
  logic [14:0] imgAddr, lbData;
  logic [7:0]  imgData = '0, palAddr;
  logic [15:0] palData = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sprite_line_renderer u_dut (
    .clk(clk), .rstN(rstN), .start(start), .lineNum(lineNum), .bankSel(bankSel),
    .recRe(recRe), .recAddr(recAddr), .recData(recData),
    .imgRe(imgRe), .imgAddr(imgAddr), .imgData(imgData),
    .palRe(palRe), .palAddr(palAddr), .palData(palData),
    .lbWe(lbWe), .lbAddr(lbAddr), .lbData(lbData), .done(done)
  );

  logic [31:0] recMem [0:511];
  logic [7:0]  imgMem [0:32767];
  logic [15:0] palMem [0:255];
  logic [8:0]  readLog  [0:LOG_N-1];
  logic [8:0]  wrAddrLog [0:LOG_N-1];
  logic [14:0] wrDataLog [0:LOG_N-1];
  int readCount = 0;
  int writeCount = 0;

  always @(posedge clk) begin
    if (recRe) begin
      recData <= recMem[recAddr];
      readLog[readCount % LOG_N] <= recAddr;
      readCount <= readCount + 1;
    end
    if (imgRe) imgData <= imgMem[imgAddr];
    if (palRe) palData <= palMem[palAddr];
    if (lbWe) begin
      wrAddrLog[writeCount % LOG_N] <= lbAddr;
      wrDataLog[writeCount % LOG_N] <= lbData;
      writeCount <= writeCount + 1;
    end
  end

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [31:0] rngState = 32'h1234_5678;

  task automatic rnd(output logic [31:0] v);
    rngState = rngState * 32'd1664525 + 32'd1013904223;
    v = rngState ^ (rngState >> 15);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  logic [15:0] expLine [0:511];
  int expWrites, expVisible;

  task automatic computeExpected(input logic [8:0] line, input bit bank);
    logic [31:0] r;
    logic [8:0]  d;
    logic [7:0]  b, idx;
    logic [15:0] p;
    for (int i = 0; i < 512; i++) expLine[i] = 16'h8000;
    expWrites = 0;
    expVisible = 0;
    for (int i = 0; i < 256; i++) begin
      r = recMem[{bank, 8'(i)}];
      d = line - r[24:16];
      if (d < 9'd16) begin
        expVisible++;
        for (int c = 0; c < 16; c++) begin
          b = imgMem[{r[31:25], d[3:0], 4'(c)}];
          case (r[12:11])
            2'b01:   idx = {1'b0, r[15:13], (r[9] ? b[7:4] : b[3:0])};
            2'b10:   idx = {3'b000, r[15:13], 2'((b >> (2 * r[10:9])) & 8'd3)};
            default: idx = b;
          endcase
          p = palMem[idx];
          if (!p[15]) begin
            expLine[9'(r[8:0] + 9'(c))] = {1'b0, p[14:0]};
            expWrites++;
          end
        end
      end
    end
  endtask

  task automatic runLine(input logic [8:0] line, input bit bank, input bit intrude,
                         input bit tight, input string tag);
    int rd0, wr0, cycles, bad, firstBad, orderBad;
    logic [15:0] got [0:511];
    computeExpected(line, bank);
    rd0 = readCount;
    wr0 = writeCount;
    @(negedge clk);
    lineNum = line; bankSel = bank; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cycles = 1;
    while (!done && cycles < 20000) begin
      @(negedge clk);
      cycles++;
      if (intrude && cycles == 10) begin
        lineNum = line ^ 9'h0AA; bankSel = ~bank; start = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    check(done, {tag, " R9 done rises (watchdog)"}, int'(done), 1);
    // R1 + R4: every record read once, in order, in the selected bank
    orderBad = 0;
    for (int k = 0; k < readCount - rd0; k++)
      if (readLog[(rd0 + k) % LOG_N] != {bank, 8'(k)}) orderBad++;
    check(readCount - rd0 == 256 && orderBad == 0, {tag, " R1 R4 record scan"},
          readCount - rd0 + orderBad * 1000, 256);
    // R2 R5 R6 R7 R8: pixel content
    for (int i = 0; i < 512; i++) got[i] = 16'h8000;
    for (int k = wr0; k < writeCount; k++) got[wrAddrLog[k % LOG_N]] = {1'b0, wrDataLog[k % LOG_N]};
    bad = 0; firstBad = -1;
    for (int i = 0; i < 512; i++)
      if (got[i] !== expLine[i]) begin
        bad++;
        if (firstBad < 0) firstBad = i;
      end
    if (bad != 0)
      $display("  pixel %0d got %h expected %h", firstBad, got[firstBad], expLine[firstBad]);
    check(bad == 0, {tag, " R2 R5 R6 R8 line content mismatching pixels"}, bad, 0);
    check(writeCount - wr0 == expWrites, {tag, " R7 write count"}, writeCount - wr0, expWrites);
    // R3 timing window
    check(cycles >= 256 && cycles >= 17 * expVisible &&
          cycles <= (tight ? 17 * expVisible + 12 : 256 + 17 * expVisible + 12),
          {tag, " R3 cycles to done"}, cycles, 17 * expVisible);
    // R9 done holds with no further activity
    wr0 = writeCount;
    repeat (6) @(negedge clk);
    check(done && writeCount == wr0 && !recRe, {tag, " R9 done holds, no writes"},
          int'(done), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    checks++;
    fails++;
    $display("FAIL R9 global watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 512; i++) begin rnd(v); recMem[i] = v; end
    for (int i = 0; i < 32768; i++) begin rnd(v); imgMem[i] = v[7:0]; end
    for (int i = 0; i < 256; i++) begin
      rnd(v);
      palMem[i] = {(v[19:18] == 2'b00), v[14:0]};
    end

    repeat (3) @(negedge clk);
    // R10: reset state
    check(!done && !recRe && !imgRe && !lbWe, "R10 reset state quiet", int'(recRe | imgRe | lbWe), 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(!done && writeCount == 0 && readCount == 0, "R10 idle before start",
          readCount + writeCount, 0);

    // sweep of lines over random content, all depth modes mixed
    for (int l = 0; l < 512; l += 37) runLine(9'(l), 1'b0, 1'b0, 1'b0, "sweep");
    runLine(9'd511, 1'b1, 1'b0, 1'b0, "bank1");

    // R9: a second start in the middle of a line is ignored
    runLine(9'd200, 1'b0, 1'b1, 1'b0, "intrude R9");

    // R4: every sprite visible, rows wrapping past line 0, x wrapping past 511
    for (int i = 0; i < 256; i++) begin
      rnd(v);
      recMem[256 + i] = {v[31:25], 9'(9'd5 - 9'(i % 16)), v[15:9], 9'(9'd500 + 9'(i % 32))};
    end
    runLine(9'd5, 1'b1, 1'b0, 1'b1, "allvis R4");

    // R2: nothing visible
    for (int i = 0; i < 256; i++) begin
      rnd(v);
      recMem[256 + i] = {v[31:25], 9'd300, v[15:0]};
    end
    runLine(9'd100, 1'b1, 1'b0, 1'b0, "none R2");
    check(expVisible == 0, "R2 empty-line setup", expVisible, 0);

    summary();
  end

endmodule